// File: doc/BRIEF.md
# GPIO Pad Control Register Bank

This block holds the per-pin settings of a general-purpose pin controller. Each pin has two words on a plain register bus. The control word holds the function select, drive strength, pull bias and output enable. The I/O word holds the synchronised pad input and the GPIO output level. From these words the block drives, for every pin, the pad output and enable, the pull-up and pull-down requests, a drive code and a function-select code for an external alternate-function mux.

Address bit 0 selects the word: 0 for control and 1 for I/O. The bits above it select the pin. Writes take effect at the clock edge on which `bus_wr` is high. Reads are combinational from `bus_addr`. Control word layout: bits [2:0] function (0 = plain GPIO), [5:3] drive code n meaning (n+1)*2 mA, [7:6] pull code, bit 8 output enable, and all higher bits read 0. I/O word layout: bit 0 is the input level (read-only), bit 1 is the output level, and higher bits read 0.

Software makes a pin an output in two steps. It first writes the output level in the I/O word, then sets output enable in the control word, so the pad never drives a stale level.

Top module: `gpio_pad_ctrl`

## Requirements
- R1: After a synchronous reset, every control word and I/O word reads 0, and every pad output, pad enable, pull request, drive code and function code is 0. This means GPIO mode, input direction, no pull and 2 mA.
- R2: A control write stores function [2:0], drive [5:3] and output enable [8]. The word reads back with all bits above 8 as 0. `func_sel` and `pad_drive` present the stored codes.
- R3: Pull code 0 requests no pull, code 1 requests pull-down (`pad_pull_dn`=1) and code 3 requests pull-up (`pad_pull_up`=1). Pull-up and pull-down are never requested together.
- R4: A control write carrying the reserved pull code 2 leaves the stored pull code unchanged. The other fields of that write are still stored.
- R5: An I/O write stores bit 1 as the output level. Bit 0 of the written data is ignored. The read-back bit 0 always shows the synchronised input.
- R6: In GPIO mode (function 0), `pad_out` equals the stored output level and `pad_oe` equals the output-enable bit. When output enable rises, the output level is already settled and does not change in that cycle.
- R7: A pad input level shows in I/O bit 0 after two rising clock edges, and not after only one.
- R8: When the function code is nonzero, `pad_out` and `pad_oe` follow `alt_out` and `alt_oe`, and the stored GPIO output level and enable have no effect.
- R9: A write to one pin changes no word of any other pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | Bit 0 selects the word, the upper bits select the pin |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr` |
| pad_in | input | NUM_PINS | Asynchronous pad input levels |
| alt_out | input | NUM_PINS | Alternate-function output levels |
| alt_oe | input | NUM_PINS | Alternate-function output enables |
| pad_out | output | NUM_PINS | Pad output level |
| pad_oe | output | NUM_PINS | Pad output enable |
| pad_pull_up | output | NUM_PINS | Pull-up request |
| pad_pull_dn | output | NUM_PINS | Pull-down request |
| pad_drive | output | 3*NUM_PINS | Drive code per pin |
| func_sel | output | 3*NUM_PINS | Function code per pin for the external mux |

## Verification
The table of control writes covers each pull code, including the reserved one written both from a no-pull state and from a pull-down state. This shows that code 2 leaves the earlier value in place rather than clearing it. The table also covers the extreme drive codes, a nonzero function, and junk in the unused upper data bits. Directed tests follow a pad input edge over one and then two clock edges, which separates a two-stage synchroniser from a shorter one. They also write the read-only input bit to show it is ignored. Finally, they set the alternate-function inputs opposite to the GPIO state, so that routing by function code is distinguished from routing by the GPIO bits.

// File: rtl/gpio_pad_pkg.sv
// Package: shared field layout and types for the pad control register bank.
// Assumes: control word fields packed from bit 0 upward as func, drive, pull, oe.
package gpio_pad_pkg;

    localparam int FUNC_W = 3;
    localparam int DRV_W  = 3;
    localparam int PULL_W = 2;

    typedef enum logic [PULL_W-1:0] {
        PULL_NONE = 2'd0,
        PULL_DOWN = 2'd1,
        PULL_RSVD = 2'd2,
        PULL_UP   = 2'd3
    } pull_e;

    // Control word, MSB first: oe[8], pull[7:6], drive[5:3], func[2:0]
    typedef struct packed {
        logic              oe;
        pull_e             pull;
        logic [DRV_W-1:0]  drive;
        logic [FUNC_W-1:0] func;
    } pin_ctl_t;

    localparam int CTL_W   = $bits(pin_ctl_t);
    localparam int IO_IN   = 0;
    localparam int IO_OUT  = 1;

endpackage

// File: rtl/gpio_in_sync.sv
// Module: two-stage synchroniser for all pad inputs.
// Assumes: pad levels are asynchronous to clk; two flops give enough settling.
module gpio_in_sync #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;
    logic [1:0]       since_rst_q;

    // Purpose: shift the pad levels through the two synchroniser stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_in;
            stage2_q <= stage1_q;
        end
    end

    // Purpose: count edges since reset so the latency check is not judged on pre-reset history.
    always_ff @(posedge clk) begin
        if (!rst_n)                 since_rst_q <= '0;
        else if (since_rst_q != 2'd3) since_rst_q <= since_rst_q + 2'd1;
    end

    assign sync_out = stage2_q;

    assert_sync_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst_q == 2'd3) |-> (stage2_q == $past(async_in, 2)))
        else $error("synchroniser latency differs from two edges");

endmodule

// File: rtl/gpio_pin_regs.sv
// Module: the control and I/O registers of one pin.
// Assumes: the top decodes the address, so at most one of ctl_we or io_we is high per cycle.
module gpio_pin_regs
    import gpio_pad_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     ctl_we,
    input  pin_ctl_t ctl_wdata,
    input  logic     io_we,
    input  logic     out_wdata,
    output pin_ctl_t ctl_q,
    output logic     out_q
);

    // Purpose: store the control fields, keeping the old pull code when the reserved code is written.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else if (ctl_we) begin
            ctl_q.func  <= ctl_wdata.func;
            ctl_q.drive <= ctl_wdata.drive;
            ctl_q.oe    <= ctl_wdata.oe;
            if (ctl_wdata.pull != PULL_RSVD) ctl_q.pull <= ctl_wdata.pull;
        end
    end

    // Purpose: store the GPIO output level from the I/O word.
    always_ff @(posedge clk) begin
        if (!rst_n)     out_q <= 1'b0;
        else if (io_we) out_q <= out_wdata;
    end

    assert_no_rsvd_pull_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.pull != PULL_RSVD)
        else $error("reserved pull code stored");

    assert_out_settled_at_oe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctl_q.oe) |-> $stable(out_q))
        else $error("output level moved as enable rose");

endmodule

// File: rtl/gpio_pad_mux.sv
// Module: the pad-side view of one pin: output source select and pull decode.
// Assumes: function code 0 is plain GPIO; any nonzero code hands the pad to the alternate function.
module gpio_pad_mux
    import gpio_pad_pkg::*;
(
    input  pin_ctl_t ctl,
    input  logic     gpio_out,
    input  logic     alt_out,
    input  logic     alt_oe,
    output logic     pad_out,
    output logic     pad_oe,
    output logic     pull_up,
    output logic     pull_dn
);
    logic alt_sel;

    // Purpose: choose between the GPIO bits and the alternate function.
    always_comb begin
        alt_sel = (ctl.func != '0);
        pad_out = alt_sel ? alt_out : gpio_out;
        pad_oe  = alt_sel ? alt_oe  : ctl.oe;
    end

    // Purpose: turn the pull code into the two pad requests.
    always_comb begin
        pull_up = (ctl.pull == PULL_UP);
        pull_dn = (ctl.pull == PULL_DOWN);
    end

    assert_pull_exclusive_R3: assert final (!(pull_up && pull_dn))
        else $error("pull-up and pull-down both requested");

endmodule

// File: rtl/gpio_pad_ctrl.sv
// Module: top of the pad control register bank; address decode, read mux, per-pin instances.
// Assumes: bus_addr[0] selects control (0) or I/O (1) word, upper bits pick the pin;
//          pin indices at or above NUM_PINS read 0 and ignore writes.
module gpio_pad_ctrl
    import gpio_pad_pkg::*;
#(
    parameter int NUM_PINS = 4,
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = $clog2(NUM_PINS) + 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bus_wr,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic [DATA_W-1:0]          bus_wdata,
    output logic [DATA_W-1:0]          bus_rdata,
    input  logic [NUM_PINS-1:0]        pad_in,
    input  logic [NUM_PINS-1:0]        alt_out,
    input  logic [NUM_PINS-1:0]        alt_oe,
    output logic [NUM_PINS-1:0]        pad_out,
    output logic [NUM_PINS-1:0]        pad_oe,
    output logic [NUM_PINS-1:0]        pad_pull_up,
    output logic [NUM_PINS-1:0]        pad_pull_dn,
    output logic [DRV_W*NUM_PINS-1:0]  pad_drive,
    output logic [FUNC_W*NUM_PINS-1:0] func_sel
);
    localparam int PIN_W = ADDR_W - 1;

    logic [PIN_W-1:0]    sel_pin;
    logic                sel_io;
    logic [NUM_PINS-1:0] in_sync;
    pin_ctl_t            ctl_q   [NUM_PINS];
    logic [NUM_PINS-1:0] out_q;
    pin_ctl_t            ctl_wdata;
    logic                unused_wdata_hi;

    assign sel_pin         = bus_addr[ADDR_W-1:1];
    assign sel_io          = bus_addr[0];
    assign ctl_wdata       = pin_ctl_t'(bus_wdata[CTL_W-1:0]);
    assign unused_wdata_hi = ^bus_wdata[DATA_W-1:CTL_W];

    gpio_in_sync #(.WIDTH(NUM_PINS)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (in_sync)
    );

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        logic hit;
        assign hit = bus_wr && (sel_pin == PIN_W'(p));

        gpio_pin_regs u_regs (
            .clk       (clk),
            .rst_n     (rst_n),
            .ctl_we    (hit && !sel_io),
            .ctl_wdata (ctl_wdata),
            .io_we     (hit && sel_io),
            .out_wdata (bus_wdata[IO_OUT]),
            .ctl_q     (ctl_q[p]),
            .out_q     (out_q[p])
        );

        gpio_pad_mux u_mux (
            .ctl      (ctl_q[p]),
            .gpio_out (out_q[p]),
            .alt_out  (alt_out[p]),
            .alt_oe   (alt_oe[p]),
            .pad_out  (pad_out[p]),
            .pad_oe   (pad_oe[p]),
            .pull_up  (pad_pull_up[p]),
            .pull_dn  (pad_pull_dn[p])
        );

        assign pad_drive[p*DRV_W +: DRV_W]   = ctl_q[p].drive;
        assign func_sel[p*FUNC_W +: FUNC_W]  = ctl_q[p].func;

        assert_other_pins_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && sel_pin != PIN_W'(p)) |=> ($stable(ctl_q[p]) && $stable(out_q[p])))
            else $error("write to another pin changed pin %0d", p);
    end

    // Purpose: return the addressed word; unused bits and absent pins read 0.
    always_comb begin
        bus_rdata = '0;
        for (int p = 0; p < NUM_PINS; p++) begin
            if (sel_pin == PIN_W'(p)) begin
                if (sel_io) begin
                    bus_rdata[IO_IN]  = in_sync[p];
                    bus_rdata[IO_OUT] = out_q[p];
                end else begin
                    bus_rdata[CTL_W-1:0] = ctl_q[p];
                end
            end
        end
    end

endmodule

// File: tb/gpio_pad_ctrl_bench.sv
`timescale 1ns/1ps
module gpio_pad_ctrl_bench;
    localparam int N      = 4;
    localparam int DW     = 32;
    localparam int AW     = 3;
    localparam int NVEC   = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic [N-1:0]  pad_in = '0, alt_out = '0, alt_oe = '0;
    logic [N-1:0]  pad_out, pad_oe, pad_pull_up, pad_pull_dn;
    logic [3*N-1:0] pad_drive, func_sel;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    gpio_pad_ctrl #(.NUM_PINS(N), .DATA_W(DW)) u_gpio_pad_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .alt_out(alt_out), .alt_oe(alt_oe), .pad_out(pad_out), .pad_oe(pad_oe),
        .pad_pull_up(pad_pull_up), .pad_pull_dn(pad_pull_dn),
        .pad_drive(pad_drive), .func_sel(func_sel)
    );

    // Vector: {pin[1:0], wdata[8:0], expected readback[8:0], exp_up, exp_dn}
    localparam logic [21:0] VEC [NVEC] = '{
        {2'd0, 9'h058, 9'h058, 1'b0, 1'b1},   // pull-down, drive 3
        {2'd1, 9'h1F8, 9'h1F8, 1'b1, 1'b0},   // pull-up, drive 7, oe
        {2'd2, 9'h005, 9'h005, 1'b0, 1'b0},   // no pull, function 5
        {2'd3, 9'h090, 9'h010, 1'b0, 1'b0},   // reserved pull from none
        {2'd0, 9'h088, 9'h048, 1'b0, 1'b1},   // reserved pull keeps pull-down
        {2'd2, 9'h000, 9'h000, 1'b0, 1'b0}    // back to GPIO, all clear
    };

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic report;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual=expired expected=done");
            report();
        end
    end

    initial begin
        logic [DW-1:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        for (int p = 0; p < N; p++) begin
            rd(AW'(2*p), d);   check("R1", "ctl after reset", d, 0);
            rd(AW'(2*p+1), d); check("R1", "io after reset", d, 0);
        end
        check("R1", "pad_out", pad_out, 0);
        check("R1", "pad_oe", pad_oe, 0);
        check("R1", "pulls", {pad_pull_up, pad_pull_dn}, 0);
        check("R1", "drive/func", {pad_drive, func_sel}, 0);

        // R2 R3 R4: table of control writes, upper data bits filled with junk
        for (int v = 0; v < NVEC; v++) begin
            logic [1:0] pin;
            logic [8:0] wd, ex;
            pin = VEC[v][21:20]; wd = VEC[v][19:11]; ex = VEC[v][10:2];
            wr({pin, 1'b0}, {23'h5A5A5A, wd});
            rd({pin, 1'b0}, d);
            check("R2", "ctl readback", d, {23'h0, ex});
            check("R2", "drive code", pad_drive[pin*3 +: 3], ex[5:3]);
            check("R2", "func code", func_sel[pin*3 +: 3], ex[2:0]);
            check("R3", "pull_up", pad_pull_up[pin], VEC[v][1]);
            check("R3", "pull_dn", pad_pull_dn[pin], VEC[v][0]);
            if (wd[7:6] == 2'd2) check("R4", "reserved pull kept old", d[7:6], ex[7:6]);
        end

        // R9: pin 0 untouched by writes to pins 1..3 after its last table write
        wr(3'd7, 32'h0000_0003);
        rd(3'd0, d); check("R9", "pin0 ctl unchanged", d, 32'h048);
        rd(3'd6, d); check("R9", "pin3 ctl unchanged", d, 32'h010);

        // R5: output bit stored, input bit write ignored (pin 1, pad_in low)
        wr(3'd3, 32'h0000_0003);
        rd(3'd3, d); check("R5", "io readback bit0 ignored", d, 32'h2);
        // R6: pin 1 is GPIO with oe=1
        check("R6", "pad_out follows out bit", pad_out[1], 1'b1);
        check("R6", "pad_oe follows oe bit", pad_oe[1], 1'b1);
        wr(3'd3, 32'h0);
        check("R6", "pad_out low", pad_out[1], 1'b0);
        wr(3'd2, 32'h0F8);
        check("R6", "pad_oe cleared", pad_oe[1], 1'b0);

        // R7: input sync latency on pin 1
        @(negedge clk); pad_in[1] = 1'b1;
        @(negedge clk); rd(3'd3, d); check("R7", "input after one edge", d[0], 1'b0);
        @(negedge clk); rd(3'd3, d); check("R7", "input after two edges", d[0], 1'b1);
        wr(3'd3, 32'h0);
        rd(3'd3, d); check("R5", "input bit survives io write", d, 32'h1);

        // R8: alternate function owns pad on pin 2, GPIO out=0 oe=0
        alt_out[2] = 1'b1; alt_oe[2] = 1'b1;
        wr(3'd4, 32'h005);
        check("R8", "alt out routed", pad_out[2], 1'b1);
        check("R8", "alt oe routed", pad_oe[2], 1'b1);
        wr(3'd4, 32'h000);
        check("R8", "gpio back in control oe", pad_oe[2], 1'b0);
        check("R8", "gpio back in control out", pad_out[2], 1'b0);

        // R1: reset again clears everything
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1; pad_in = '0;
        rd(3'd0, d); check("R1", "ctl after re-reset", d, 0);
        check("R1", "pulls after re-reset", {pad_pull_up, pad_pull_dn}, 0);

        done = 1'b1;
        report();
    end
endmodule